// File: doc/BRIEF.md
# Serial NOR Flash Status and Busy Tracker

This block holds the status byte of a serial NOR flash device model. An SPI front end, outside this block, does the bit shifting. It hands over three things: a strobe for the first byte of each transaction (the opcode), a strobe for every later byte, and a strobe for the rising edge of chip select. From these the block keeps the write-enable latch and the write-in-progress flag. It decides whether a program, erase or status-write command may run. It models the cycle time of each such operation with a countdown measured in clock ticks.

A write-class command runs only when the enable latch is set and no operation is in progress. It takes effect when chip select rises. At that point the enable latch drops, the busy flag rises and the countdown loads with that operation's cycle time. When the countdown runs out, both the busy flag and the enable latch clear. A status read returns the current status byte once for the opcode and again for each further byte of the same transaction. A status write changes only a masked middle field of the register.

Top module: `flash_status_tracker`

## Requirements
- R1: After reset the status byte is 0x1C and `rdValid` is low. Throughout, bit 0 of the status byte is the busy flag and bit 1 is the write-enable latch.
- R2: Opcode 0x06 sets bit 1 and opcode 0x04 clears it. Either change is visible on the clock edge that accepts the opcode strobe.
- R3: The write-class opcodes are 0x01, 0x02, 0x32, 0x20, 0xD8 and 0xC7. Each runs only when bit 1 is 1 and bit 0 is 0 at the opcode edge. Otherwise the whole transaction is ignored, and the chip-select rise that ends it leaves the status byte and the countdown unchanged.
- R4: On the chip-select rise that ends an accepted write-class transaction, bit 1 clears, bit 0 sets and the countdown loads the cycle time of that operation. Page programs (0x02, 0x32), 4 KB erase (0x20), 64 KB erase (0xD8), full erase (0xC7) and status write (0x01) each have their own parameter. Bit 0 then stays high for exactly that many clock cycles.
- R5: When the countdown reaches zero, bits 0 and 1 both clear in the same cycle.
- R6: A status write commits only if exactly one data byte followed opcode 0x01. It replaces the bits under mask 0x7C and keeps bits 7, 1 and 0. With zero or more than one data byte, nothing changes and bit 1 stays set.
- R7: Opcode 0x05, and every later byte in the same transaction, pulses `rdValid` for one cycle. At the same time `rdData` loads the status byte as it stood just before that clock edge.
- R8: Opcodes 0x06 and 0x04 issued while bit 0 is 1 still update bit 1. They neither reload nor shorten the running countdown.
- R9: If opcode 0x06 or 0x04 arrives on the same edge where the countdown expires, bit 0 clears and bit 1 takes the value the opcode requests.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one countdown tick per cycle |
| rstN | input | 1 | Active-low synchronous reset |
| opValid | input | 1 | First byte of a transaction is in `opCode` |
| opCode | input | 8 | Received opcode |
| byteValid | input | 1 | A later byte of the transaction is in `byteData` |
| byteData | input | 8 | Received data or address byte |
| csRise | input | 1 | Chip select has just been deasserted |
| status | output | 8 | Current status byte |
| rdData | output | 8 | Status byte served to a read |
| rdValid | output | 1 | One-cycle pulse when `rdData` is loaded |

## Verification
Two events can land on the same clock edge: the countdown running out, and a write-enable or write-disable opcode. The bench starts an operation, counts the cycles until exactly one tick is left, and then presents opcode 0x06 or 0x04 on that edge. It expects the busy flag to be clear and the enable latch to hold what the opcode asked for. A status-read byte is also timed onto the expiry edge. That read must return the byte from before the edge, with the busy flag still set, while the register itself already shows it clear.

// File: rtl/flash_status_pkg.sv
package flash_status_pkg;

  typedef enum logic [2:0] {
    OP_NONE, OP_PAGE, OP_SUBERASE, OP_SECTERASE, OP_BULKERASE, OP_WRSTAT
  } busyKindT;

  typedef struct packed {
    logic     setWel;
    logic     clrWel;
    logic     start;
    busyKindT kind;
    logic     commitSr;
    logic [7:0] srData;
    logic     capRead;
  } strobeT;

  localparam logic [7:0] CMD_WREN    = 8'h06;
  localparam logic [7:0] CMD_WRDI    = 8'h04;
  localparam logic [7:0] CMD_RDSTAT  = 8'h05;
  localparam logic [7:0] CMD_WRSTAT  = 8'h01;
  localparam logic [7:0] CMD_PAGE    = 8'h02;
  localparam logic [7:0] CMD_PAGEQ   = 8'h32;
  localparam logic [7:0] CMD_SUBER   = 8'h20;
  localparam logic [7:0] CMD_SECTER  = 8'hD8;
  localparam logic [7:0] CMD_BULKER  = 8'hC7;

  localparam logic [7:0] STAT_RESET   = 8'h1C;
  localparam logic [7:0] STAT_WR_MASK = 8'h7C;

  function automatic busyKindT kindOf(input logic [7:0] c);
    case (c)
      CMD_WRSTAT:          kindOf = OP_WRSTAT;
      CMD_PAGE, CMD_PAGEQ: kindOf = OP_PAGE;
      CMD_SUBER:           kindOf = OP_SUBERASE;
      CMD_SECTER:          kindOf = OP_SECTERASE;
      CMD_BULKER:          kindOf = OP_BULKERASE;
      default:             kindOf = OP_NONE;
    endcase
  endfunction

endpackage

// File: rtl/flash_status_ctrl.sv
module flash_status_ctrl
  import flash_status_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       opValid,
  input  logic [7:0] opCode,
  input  logic       byteValid,
  input  logic [7:0] byteData,
  input  logic       csRise,
  input  logic       welNow,
  input  logic       wipNow,
  output strobeT     stb
);

  typedef enum logic [2:0] {TX_IDLE, TX_RDSTAT, TX_WRSTAT, TX_BUSYOP, TX_IGNORE} txStateT;

  txStateT    txState;
  busyKindT   pendKind;
  logic [1:0] byteCnt;
  logic [7:0] srLatch;
  busyKindT   opKind;
  logic       gateOpen;

  assign opKind   = kindOf(opCode);
  assign gateOpen = welNow && !wipNow;

  always_comb begin
    stb = '0;
    stb.kind = OP_NONE;
    if (csRise) begin
      if (txState == TX_BUSYOP) begin
        stb.start = 1'b1;
        stb.kind  = pendKind;
      end else if (txState == TX_WRSTAT && byteCnt == 2'd1) begin
        stb.start    = 1'b1;
        stb.kind     = OP_WRSTAT;
        stb.commitSr = 1'b1;
        stb.srData   = srLatch;
      end
    end else if (opValid) begin
      stb.setWel  = (opCode == CMD_WREN);
      stb.clrWel  = (opCode == CMD_WRDI);
      stb.capRead = (opCode == CMD_RDSTAT);
    end else if (byteValid && txState == TX_RDSTAT) begin
      stb.capRead = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txState  <= TX_IDLE;
      pendKind <= OP_NONE;
      byteCnt  <= '0;
      srLatch  <= '0;
    end else if (csRise) begin
      txState  <= TX_IDLE;
      pendKind <= OP_NONE;
      byteCnt  <= '0;
    end else if (opValid) begin
      byteCnt <= '0;
      if (opCode == CMD_RDSTAT) begin
        txState <= TX_RDSTAT;
      end else if (opKind == OP_NONE || !gateOpen) begin
        txState <= TX_IGNORE;
      end else if (opKind == OP_WRSTAT) begin
        txState <= TX_WRSTAT;
      end else begin
        txState  <= TX_BUSYOP;
        pendKind <= opKind;
      end
    end else if (byteValid) begin
      if (byteCnt != 2'd3) byteCnt <= byteCnt + 2'd1;
      if (txState == TX_WRSTAT && byteCnt == 2'd0) srLatch <= byteData;
    end
  end

  AST_GATE_REJECT: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && !csRise && opKind != OP_NONE && !gateOpen) |=> txState == TX_IGNORE); // R3

  AST_START_ON_CS: assert property (@(posedge clk) disable iff (!rstN)
    stb.start |-> csRise); // R4

  AST_SR_NEEDS_STATE: assert property (@(posedge clk) disable iff (!rstN)
    (csRise && txState != TX_WRSTAT) |-> !stb.commitSr); // R6

endmodule

// File: rtl/flash_status_data.sv
module flash_status_data
  import flash_status_pkg::*;
#(
  parameter int unsigned T_PAGE  = 500,
  parameter int unsigned T_SUBER = 250000,
  parameter int unsigned T_SECT  = 700000,
  parameter int unsigned T_BULK  = 32000000,
  parameter int unsigned T_WRSR  = 1300
) (
  input  logic       clk,
  input  logic       rstN,
  input  strobeT     stb,
  output logic [7:0] status,
  output logic [7:0] rdData,
  output logic       rdValid
);

  localparam int unsigned TMAX01 = (T_PAGE > T_SUBER) ? T_PAGE : T_SUBER;
  localparam int unsigned TMAX23 = (T_SECT > T_BULK) ? T_SECT : T_BULK;
  localparam int unsigned TMAXA  = (TMAX01 > TMAX23) ? TMAX01 : TMAX23;
  localparam int unsigned TMAX   = (TMAXA > T_WRSR) ? TMAXA : T_WRSR;
  localparam int CW = $clog2(TMAX + 1);

  logic [7:0]    statReg;
  logic [CW-1:0] cnt;
  logic [CW-1:0] loadVal;
  logic [7:0]    statNext;
  logic          expiring;

  always_comb begin
    case (stb.kind)
      OP_PAGE:      loadVal = CW'(T_PAGE);
      OP_SUBERASE:  loadVal = CW'(T_SUBER);
      OP_SECTERASE: loadVal = CW'(T_SECT);
      OP_BULKERASE: loadVal = CW'(T_BULK);
      OP_WRSTAT:    loadVal = CW'(T_WRSR);
      default:      loadVal = '0;
    endcase
  end

  assign expiring = (cnt == CW'(1));

  always_comb begin
    statNext = statReg;
    if (expiring) statNext[1:0] = 2'b00;
    if (stb.setWel) statNext[1] = 1'b1;
    if (stb.clrWel) statNext[1] = 1'b0;
    if (stb.commitSr)
      statNext = (statNext & ~STAT_WR_MASK) | (stb.srData & STAT_WR_MASK);
    if (stb.start) statNext[1:0] = 2'b01;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statReg <= STAT_RESET;
      cnt     <= '0;
      rdData  <= '0;
      rdValid <= 1'b0;
    end else begin
      statReg <= statNext;
      if (stb.start)       cnt <= loadVal;
      else if (cnt != '0)  cnt <= cnt - CW'(1);
      rdValid <= stb.capRead;
      if (stb.capRead) rdData <= statReg;
    end
  end

  assign status = statReg;

  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    stb.start |=> (status[1:0] == 2'b01)); // R4

  AST_EXPIRE_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (expiring && !stb.setWel && !stb.start) |=> (status[1:0] == 2'b00)); // R5

  AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (cnt > CW'(1)) |=> status[0]); // R8

  AST_TOP_BIT_FIXED: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> status[7] == $past(status[7])); // R6

  AST_READ_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> rdData == $past(status)); // R7

endmodule

// File: rtl/flash_status_tracker.sv
module flash_status_tracker
  import flash_status_pkg::*;
#(
  parameter int unsigned T_PAGE  = 500,
  parameter int unsigned T_SUBER = 250000,
  parameter int unsigned T_SECT  = 700000,
  parameter int unsigned T_BULK  = 32000000,
  parameter int unsigned T_WRSR  = 1300
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       opValid,
  input  logic [7:0] opCode,
  input  logic       byteValid,
  input  logic [7:0] byteData,
  input  logic       csRise,
  output logic [7:0] status,
  output logic [7:0] rdData,
  output logic       rdValid
);

  strobeT stb;

  flash_status_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opCode(opCode),
    .byteValid(byteValid), .byteData(byteData), .csRise(csRise),
    .welNow(status[1]), .wipNow(status[0]), .stb(stb)
  );

  flash_status_data #(
    .T_PAGE(T_PAGE), .T_SUBER(T_SUBER), .T_SECT(T_SECT),
    .T_BULK(T_BULK), .T_WRSR(T_WRSR)
  ) uData (
    .clk(clk), .rstN(rstN), .stb(stb),
    .status(status), .rdData(rdData), .rdValid(rdValid)
  );

endmodule

// File: tb/flash_status_tracker_test.sv
module flash_status_tracker_test;

  localparam int TP = 5, TS = 6, TSE = 7, TB = 8, TW = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic opValid = 1'b0;
  logic [7:0] opCode = '0;
  logic byteValid = 1'b0;
  logic [7:0] byteData = '0;
  logic csRise = 1'b0;
  logic [7:0] status, rdData;
  logic rdValid;

  int nChecks = 0;
  int nFails = 0;
  logic [7:0] base;

  always #5 clk = ~clk;

  flash_status_tracker #(
    .T_PAGE(TP), .T_SUBER(TS), .T_SECT(TSE), .T_BULK(TB), .T_WRSR(TW)
  ) uut (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opCode(opCode),
    .byteValid(byteValid), .byteData(byteData), .csRise(csRise),
    .status(status), .rdData(rdData), .rdValid(rdValid)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic sendOp(input logic [7:0] c);
    opValid = 1'b1; opCode = c;
    @(negedge clk);
    opValid = 1'b0;
  endtask

  task automatic sendByte(input logic [7:0] d);
    byteValid = 1'b1; byteData = d;
    @(negedge clk);
    byteValid = 1'b0;
  endtask

  task automatic csEnd();
    csRise = 1'b1;
    @(negedge clk);
    csRise = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int timeOf(input logic [7:0] c);
    case (c)
      8'h02, 8'h32: timeOf = TP;
      8'h20:        timeOf = TS;
      8'hD8:        timeOf = TSE;
      8'hC7:        timeOf = TB;
      default:      timeOf = TW;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", nChecks + 1 - nFails, nChecks + 1);
    $finish;
  end

  initial begin
    logic [7:0] ops [6];
    ops = '{8'h02, 8'h32, 8'h20, 8'hD8, 8'hC7, 8'h02};
    idle(3);
    rstN = 1'b1;
    idle(1);
    base = 8'h1C;
    check("R1 reset status", status, 8'h1C);
    check("R1 reset rdValid", {7'd0, rdValid}, 8'h00);

    // R2 enable and disable
    sendOp(8'h06); check("R2 set WEL", status, base | 8'h02);
    csEnd();
    sendOp(8'h04); check("R2 clear WEL", status, base);
    csEnd();

    // R3 write-class opcode without WEL is ignored
    sendOp(8'hD8); sendByte(8'h00); sendByte(8'h10); sendByte(8'h00);
    csEnd(); check("R3 no WEL erase ignored", status, base);
    idle(1); check("R3 no WEL still idle", status, base);
    sendOp(8'h01); sendByte(8'hFF); csEnd();
    check("R3 no WEL status write ignored", status, base);

    // R4 R5 each operation's busy window
    for (int k = 0; k < 5; k++) begin
      int t;
      t = timeOf(ops[k]);
      sendOp(8'h06); sendOp(ops[k]);
      sendByte(8'h01); sendByte(8'h02); sendByte(8'h03);
      csEnd();
      check("R4 busy after cs", status, base | 8'h01);
      idle(t - 1); check("R4 busy at last tick", status, base | 8'h01);
      idle(1); check("R5 expiry clears", status, base);
    end

    // R6 sweep all data values through status write
    for (int v = 0; v < 256; v++) begin
      logic [7:0] nb;
      nb = (base & ~8'h7C) | (8'(v) & 8'h7C);
      sendOp(8'h06); sendOp(8'h01); sendByte(8'(v)); csEnd();
      check("R6 masked commit", status, nb | 8'h01);
      idle(TW - 1); check("R4 status-write busy", status, nb | 8'h01);
      idle(1); check("R5 status-write done", status, nb);
      base = nb;
    end

    // R6 wrong byte counts are ignored
    sendOp(8'h06); sendOp(8'h01); sendByte(8'h00); sendByte(8'h00); csEnd();
    check("R6 two bytes ignored", status, base | 8'h02);
    sendOp(8'h01); csEnd();
    check("R6 zero bytes ignored", status, base | 8'h02);
    sendOp(8'h04); csEnd();
    check("R2 clear after ignored write", status, base);

    // R7 status read, idle then during busy across expiry
    sendOp(8'h05);
    check("R7 read valid", {7'd0, rdValid}, 8'h01);
    check("R7 read data", rdData, base);
    sendByte(8'h00);
    check("R7 repeat valid", {7'd0, rdValid}, 8'h01);
    check("R7 repeat data", rdData, base);
    csEnd();
    check("R7 pulse ends", {7'd0, rdValid}, 8'h00);
    sendOp(8'h06); sendOp(8'hC7); csEnd();           // cnt = TB
    idle(2);                                          // TB-2
    sendOp(8'h05);                                    // TB-3
    check("R7 read during busy", rdData, base | 8'h01);
    idle(TB - 4);                                     // 1 left
    sendByte(8'h00);                                  // expiry edge
    check("R7 read before expiry edge", rdData, base | 8'h01);
    check("R5 expired under read", status, base);
    csEnd();

    // R8 and R3: WEL during busy, rejected command, no reload
    sendOp(8'h06); sendOp(8'h02); csEnd();           // cnt = 5
    sendOp(8'h06);                                    // 4
    check("R8 WEL set while busy", status, base | 8'h03);
    sendOp(8'h20);                                    // 3, rejected
    csEnd();                                          // 2
    check("R3 busy rejects, no reload", status, base | 8'h03);
    idle(1);                                          // 1
    check("R8 still busy", status, base | 8'h03);
    idle(1);
    check("R8 countdown not stretched", status, base);

    // R9 same-edge expiry with write enable
    sendOp(8'h06); sendOp(8'h32); csEnd();           // cnt = 5
    idle(TP - 1);                                     // 1 left
    sendOp(8'h06);
    check("R9 enable on expiry edge", status, base | 8'h02);
    csEnd();
    sendOp(8'h20); csEnd();                           // cnt = 6
    idle(2);                                          // 4
    sendOp(8'h06);                                    // 3
    check("R8 enable mid busy", status, base | 8'h03);
    idle(2);                                          // 1
    sendOp(8'h04);
    check("R9 disable on expiry edge", status, base);
    csEnd();

    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule